// File: doc/BRIEF.md
# Bytewide Nonvolatile RAM Bus Controller

This block sits between a simple on-chip request port and an external bytewide nonvolatile RAM whose address is captured on the falling edge of chip enable. Each accepted request becomes one complete strobe sequence. The controller sets up the address, pulls chip enable low for the access window, raises it again and holds it high for the precharge window. Only then does it accept the next request. A write finishes inside its own bus cycle, so no status polling is needed afterwards.

Reads assert output enable while chip enable is low. The data bus is sampled on the last cycle of the access window, and the byte is returned with a one-cycle valid pulse. Writes lower write enable one cycle before chip enable falls. Chip enable rises first and ends the write, and write enable follows a cycle later. The controller drives the data bus only while write enable is low, and it never asserts output enable during a write. All timing windows are cycle counts derived from nanosecond parameters and the clock period. A diagnostic counter reports how many consecutive accepted requests fell into the same 4-byte row.

Top module: `nvram_bus_ctrl`

## Requirements
- R1: After reset the chip enable, write enable and output enable outputs are high (inactive), the data bus is not driven, the response valid is low, the same-row counter is 0 and the request ready is high.
- R2: The request ready is high only while the controller is idle. It is low from the cycle after acceptance until the precharge window has ended, and it is never high while chip enable is low.
- R3: Every access opens with a chip enable falling edge. The memory address equals the request address at that edge and in the cycle before it, and it stays unchanged while chip enable is low.
- R4: Chip enable stays low for exactly ceil(T_ACCESS_NS / CLK_PERIOD_NS) cycles per access (24 at defaults), and never longer than the maximum-low bound.
- R5: Between two accesses chip enable stays high for at least ceil((T_CYCLE_NS − T_ACCESS_NS) / CLK_PERIOD_NS) cycles (12 at defaults).
- R6: For a write, write enable is low in the cycle before chip enable falls, stays low through the access, and is still low in the first cycle after chip enable rises. It is high from the second cycle after the rise. The data bus is driven (mem_dq_oe_o=1) with the request data only while write enable is low, and output enable stays high throughout.
- R7: For a read, output enable is low exactly while chip enable is low, write enable stays high, and the bus is not driven. The returned byte is the value on mem_dq_i in the last cycle of the access window.
- R8: rsp_valid_o pulses for exactly one cycle, in the first cycle after chip enable rises, and only for reads.
- R9: From acceptance, the ready output returns high after exactly 1 + access + precharge cycles (37 at defaults). No status polling is needed, and a read right after a write returns the written byte.
- R10: The same-row counter (row = address bits 12:2) is updated at acceptance. It becomes 0 when the row differs from the previous accepted request's row (or there was none), and otherwise it increments, saturating at 2^ROW_CNT_W − 1 (255 at defaults).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 13 | Byte address |
| req_wdata_i | input | 8 | Write data |
| rsp_valid_o | output | 1 | Read data valid pulse |
| rsp_rdata_o | output | 8 | Read data |
| mem_addr_o | output | 13 | Memory address |
| mem_ce_n_o | output | 1 | Chip enable, active low |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_dq_o | output | 8 | Data driven toward memory |
| mem_dq_oe_o | output | 1 | High when the controller drives the data bus |
| mem_dq_i | input | 8 | Data returned from memory |
| same_row_cnt_o | output | 8 | Consecutive same-row request counter |

## Verification
Directed writes followed by reads of the same byte separate a write that really reaches the memory model from one that only changes strobes. A read of a never-written byte shows that stale data is not returned. The memory model presents valid data only in the last cycle of the access window, so sampling even one cycle early returns a wrong byte. A long run of a mixed random stream of reads and writes across several rows and high-address blocks tests the strobe ordering and window lengths on every transaction. A long run to a single row drives the same-row counter into saturation, and the row changes in the random stream show it resetting.

// File: rtl/nvram_ctrl_pkg.sv
`timescale 1ns/1ps
package nvram_ctrl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACTIVE = 2'd2,
    ST_PRECH  = 2'd3
  } nv_state_e;

  function automatic int ns_to_cycles(int ns, int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction
endpackage

// File: rtl/nvram_phase_timer.sv
`timescale 1ns/1ps
module nvram_phase_timer #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else            cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/nvram_row_tracker.sv
`timescale 1ns/1ps
module nvram_row_tracker #(
  parameter int ROW_W = 11,
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic [ROW_W-1:0] row_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic             have_q;
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q <= 1'b0;
      row_q  <= '0;
      cnt_o  <= '0;
    end else if (take_i) begin
      have_q <= 1'b1;
      row_q  <= row_i;
      if (have_q && row_q == row_i) begin
        if (!(&cnt_o)) cnt_o <= cnt_o + 1'b1;
      end else begin
        cnt_o <= '0;
      end
    end
  end

  // R10: counter moves only at acceptance, by +1, to 0, or holds at max
  a_r10_row_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> (cnt_o == '0 || cnt_o == $past(cnt_o) + 1'b1 || ((&$past(cnt_o)) && (&cnt_o))));
  a_r10_row_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_i |=> $stable(cnt_o));
endmodule

// File: rtl/nvram_bus_ctrl.sv
`timescale 1ns/1ps
module nvram_bus_ctrl
  import nvram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 13,
  parameter int DATA_W        = 8,
  parameter int ROW_LSB       = 2,
  parameter int ROW_CNT_W     = 8,
  parameter int CLK_PERIOD_NS = 5,
  parameter int T_ACCESS_NS   = 120,
  parameter int T_CYCLE_NS    = 180,
  parameter int T_CE_MAX_NS   = 10000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic                 req_write_i,
  input  logic [ADDR_W-1:0]    req_addr_i,
  input  logic [DATA_W-1:0]    req_wdata_i,
  output logic                 rsp_valid_o,
  output logic [DATA_W-1:0]    rsp_rdata_o,
  output logic [ADDR_W-1:0]    mem_addr_o,
  output logic                 mem_ce_n_o,
  output logic                 mem_we_n_o,
  output logic                 mem_oe_n_o,
  output logic [DATA_W-1:0]    mem_dq_o,
  output logic                 mem_dq_oe_o,
  input  logic [DATA_W-1:0]    mem_dq_i,
  output logic [ROW_CNT_W-1:0] same_row_cnt_o
);
  localparam int ACC_CYC    = ns_to_cycles(T_ACCESS_NS, CLK_PERIOD_NS);
  localparam int PC_CYC     = ns_to_cycles(T_CYCLE_NS - T_ACCESS_NS, CLK_PERIOD_NS);
  localparam int CE_MAX_CYC = T_CE_MAX_NS / CLK_PERIOD_NS;
  localparam int ACT_CYC    = (ACC_CYC < CE_MAX_CYC) ? ACC_CYC : CE_MAX_CYC;
  localparam int TMR_MAX    = (ACT_CYC > PC_CYC) ? ACT_CYC : PC_CYC;
  localparam int TMR_W      = $clog2(TMR_MAX + 1);
  localparam int ROW_W      = ADDR_W - ROW_LSB;
  localparam int MON_W      = $clog2(CE_MAX_CYC + PC_CYC + 2);

  nv_state_e          st_q;
  logic               is_wr_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  wdata_q;
  logic [DATA_W-1:0]  rdata_q;
  logic               rvalid_q;
  logic [TMR_W-1:0]   cnt;
  logic               act_last, pc_last, tmr_clr, accept;

  assign act_last = (st_q == ST_ACTIVE) && (cnt == TMR_W'(ACT_CYC - 1));
  assign pc_last  = (st_q == ST_PRECH)  && (cnt == TMR_W'(PC_CYC - 1));
  assign tmr_clr  = (st_q == ST_IDLE) || (st_q == ST_SETUP) || act_last || pc_last;
  assign accept   = (st_q == ST_IDLE) && req_valid_i;

  nvram_phase_timer #(.W(TMR_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (tmr_clr),
    .cnt_o  (cnt)
  );

  nvram_row_tracker #(.ROW_W(ROW_W), .CNT_W(ROW_CNT_W)) u_rows (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .take_i (accept),
    .row_i  (req_addr_i[ADDR_W-1:ROW_LSB]),
    .cnt_o  (same_row_cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      is_wr_q  <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          is_wr_q <= req_write_i;
          addr_q  <= req_addr_i;
          wdata_q <= req_wdata_i;
          st_q    <= ST_SETUP;
        end
        ST_SETUP: st_q <= ST_ACTIVE;
        ST_ACTIVE: if (act_last) begin
          st_q <= ST_PRECH;
          if (!is_wr_q) begin
            rdata_q  <= mem_dq_i;
            rvalid_q <= 1'b1;
          end
        end
        ST_PRECH: if (pc_last) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // write enable leads chip enable by one cycle and trails it by one
  logic we_act;
  assign we_act = is_wr_q && ((st_q == ST_SETUP) || (st_q == ST_ACTIVE) ||
                              ((st_q == ST_PRECH) && (cnt == '0)));

  assign req_ready_o = (st_q == ST_IDLE);
  assign mem_addr_o  = addr_q;
  assign mem_ce_n_o  = (st_q != ST_ACTIVE);
  assign mem_we_n_o  = !we_act;
  assign mem_oe_n_o  = !((st_q == ST_ACTIVE) && !is_wr_q);
  assign mem_dq_o    = wdata_q;
  assign mem_dq_oe_o = we_act;
  assign rsp_valid_o = rvalid_q;
  assign rsp_rdata_o = rdata_q;

  // run-length monitors for the timing checks
  logic [MON_W-1:0] low_run, high_run;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_run  <= '0;
      high_run <= MON_W'(PC_CYC);
    end else if (!mem_ce_n_o) begin
      low_run  <= low_run + 1'b1;
      high_run <= '0;
    end else begin
      low_run  <= '0;
      if (high_run < MON_W'(PC_CYC)) high_run <= high_run + 1'b1;
    end
  end

  a_r2_ready_ce_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> mem_ce_n_o);
  a_r3_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_ce_n_o |-> $stable(mem_addr_o));
  a_r4_ce_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_ce_n_o |-> (low_run < MON_W'(CE_MAX_CYC)));
  a_r5_precharge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_ce_n_o) |-> (high_run >= MON_W'(PC_CYC)));
  a_r6_we_leads_ce: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(mem_ce_n_o) && !mem_we_n_o) |-> !$past(mem_we_n_o));
  a_r6_we_trails_ce: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(mem_ce_n_o) && !$past(mem_we_n_o)) |-> !mem_we_n_o);
  a_r6_no_contention: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_n_o);
  a_r7_oe_inside_ce: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_n_o |-> (!mem_ce_n_o && mem_we_n_o));
  a_r8_rsp_at_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $rose(mem_ce_n_o));
  a_r8_rsp_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
endmodule

// File: tb/nvram_bus_ctrl_test.sv
`timescale 1ns/1ps
module nvram_bus_ctrl_test;
  localparam int ACC  = 24;
  localparam int PC   = 12;
  localparam int BUSY = 1 + ACC + PC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic        req_ready;
  logic [12:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [12:0] mem_addr;
  logic        ce_n, we_n, oe_n, dq_oe;
  logic [7:0]  dq_o, dq_i;
  logic [7:0]  same_row;

  always #2.5 clk = ~clk;

  nvram_bus_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .mem_addr_o(mem_addr), .mem_ce_n_o(ce_n), .mem_we_n_o(we_n), .mem_oe_n_o(oe_n),
    .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i),
    .same_row_cnt_o(same_row)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] cells  [64];
  logic [7:0] shadow [64];

  function automatic logic [5:0] ix(logic [12:0] a);
    return {a[12:11], a[3:0]};
  endfunction
  function automatic logic [12:0] ad(logic [5:0] i);
    return {i[5:4], 7'd0, i[3:0]};
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=0x%0h exp=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // memory model and strobe monitor
  bit          cur_write = 1'b0;
  logic [12:0] cur_addr = '0;
  logic [7:0]  cur_data = '0, cur_exp = '0;
  logic [12:0] lat = '0;
  int          lowcnt = 0, low_run = 0, high_run = 100;
  logic        prev_ce = 1'b1, prev_we = 1'b1;
  logic [12:0] prev_addr = '0;

  assign dq_i = (!ce_n && !oe_n && we_n && lowcnt >= ACC) ? cells[ix(lat)] : ~cells[ix(lat)];

  always @(negedge clk) begin
    if (rst_n) begin
      if (!ce_n) begin
        if (lowcnt == 0) lat = mem_addr;
        lowcnt++;
        if (prev_ce) begin
          chk(high_run >= PC, "R5 precharge length", high_run, PC);
          chk(mem_addr == cur_addr, "R3 address at ce fall", mem_addr, cur_addr);
          chk(prev_addr == cur_addr, "R3 address before ce fall", prev_addr, cur_addr);
          chk(we_n == !cur_write, "R6 we at ce fall", we_n, !cur_write);
          if (cur_write) chk(prev_we == 1'b0, "R6 we leads ce", prev_we, 0);
          low_run = 1;
        end else begin
          low_run++;
          chk(mem_addr == prev_addr, "R3 address stable", mem_addr, prev_addr);
        end
        chk(oe_n == cur_write, "R7 oe during access", oe_n, cur_write);
        chk(dq_oe == cur_write, "R6 bus drive", dq_oe, cur_write);
        if (cur_write) chk(dq_o == cur_data, "R6 write data", dq_o, cur_data);
        chk(req_ready == 1'b0, "R2 ready while ce low", req_ready, 0);
      end else begin
        lowcnt = 0;
        chk(oe_n == 1'b1, "R7 oe high while ce high", oe_n, 1);
        if (!prev_ce) begin
          chk(low_run == ACC, "R4 ce low length", low_run, ACC);
          chk(rsp_valid == !cur_write, "R8 response pulse", rsp_valid, !cur_write);
          if (!cur_write) chk(rsp_rdata == cur_exp, "R7 read data", rsp_rdata, cur_exp);
          if (cur_write) begin
            chk(we_n == 1'b0, "R6 we trails ce", we_n, 0);
            if (dq_oe) cells[ix(lat)] = dq_o;
          end
          high_run = 1;
        end else begin
          high_run++;
          chk(rsp_valid == 1'b0, "R8 no extra response", rsp_valid, 0);
          if (high_run == 2) begin
            chk(we_n == 1'b1, "R6 we released", we_n, 1);
            chk(dq_oe == 1'b0, "R6 bus released", dq_oe, 0);
          end
        end
      end
      prev_ce   = ce_n;
      prev_we   = we_n;
      prev_addr = mem_addr;
    end
  end

  // request driver with expected row counter
  bit          have_row = 1'b0;
  logic [10:0] prev_row = '0;
  int          erow = 0;

  task automatic do_req(bit w, logic [5:0] i, logic [7:0] d);
    logic [10:0] row;
    int n;
    @(negedge clk);
    cur_write = w; cur_addr = ad(i); cur_data = d;
    cur_exp   = w ? d : shadow[i];
    req_write = w; req_addr = ad(i); req_wdata = d; req_valid = 1'b1;
    chk(req_ready == 1'b1, "R2 ready when idle", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    req_write = $urandom_range(0, 1);
    req_addr  = 13'($urandom);
    if (w) shadow[i] = d;
    row = ad(i)[12:2];
    if (have_row && row == prev_row) erow = (erow == 255) ? 255 : erow + 1;
    else erow = 0;
    have_row = 1'b1; prev_row = row;
    chk(same_row == 8'(erow), "R10 same-row counter", same_row, erow);
    n = 0;
    while (!req_ready && n < 200) begin
      n++;
      @(negedge clk);
    end
    chk(n == BUSY, "R9 turnaround", n, BUSY);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < 64; k++) begin
      cells[k]  = 8'(k) ^ 8'h3C;
      shadow[k] = 8'(k) ^ 8'h3C;
    end
    #1;
    chk(ce_n == 1'b1 && we_n == 1'b1 && oe_n == 1'b1, "R1 strobes idle", {ce_n, we_n, oe_n}, 7);
    chk(dq_oe == 1'b0 && rsp_valid == 1'b0, "R1 bus and response idle", {dq_oe, rsp_valid}, 0);
    chk(same_row == 8'd0 && req_ready == 1'b1, "R1 counter and ready", {same_row, req_ready}, 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // directed: write then immediate read-back, untouched byte, row changes
    do_req(1'b1, 6'd5, 8'hC3);
    do_req(1'b0, 6'd5, 8'h00);
    do_req(1'b0, 6'd40, 8'h00);
    do_req(1'b1, 6'd63, 8'h7E);
    do_req(1'b1, 6'd62, 8'h81);
    do_req(1'b0, 6'd63, 8'h00);
    do_req(1'b0, 6'd1, 8'h00);
    // random mix
    for (int t = 0; t < 150; t++)
      do_req(1'($urandom_range(0, 1)), 6'($urandom_range(0, 63)), 8'($urandom));
    // single-row run into saturation
    for (int t = 0; t < 260; t++)
      do_req(1'b0, 6'($urandom_range(8, 11)), 8'h00);
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(190000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL R9 watchdog expired: act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule